// File: doc/BRIEF.md
# Programmable Buzzer PWM Generator

This block drives a single-ended buzzer pin. A carrier square wave runs at a programmed frequency. Its high time is set by a 6-bit duty code counted in 1/128 parts of the period, and a polarity bit chooses whether that width applies to the logic-1 or the logic-0 phase. When asked to, the carrier is also switched on and off by a slower square wave with a 50% duty. This gives an amplitude-gated, ringing sound.

Both frequencies come from phase accumulators. Each accumulator adds its 8-bit code once per range tick. A shared prescaler derives that tick from a base strobe and the 2-bit range select. In the standard range, with the base strobe at 1.024 MHz, the carrier frequency is code/0.128 Hz. The halved range gives half that frequency and the doubled range gives twice it. The register file outside the block holds the configuration, and its power-on values leave the buzzer disabled with the duty referred to logic 1. Disabling the block or powering it down clears both accumulators. Every enable therefore starts from phase zero.

Top module: `buzz_pwm_gen`

## Requirements
- R1: In the standard range (range code 00), the carrier accumulator advances by the carrier code on every 2nd base strobe. A 16-bit phase then completes one period every 2·65536/code base strobes, for example 1024 clocks for code 128 when the base strobe fires every clock.
- R2: Range code 01 advances the accumulators on every 4th base strobe, which halves the frequency. Range code 10 advances them on every base strobe, which doubles it. The reserved code 11 behaves exactly like 00.
- R3: With the polarity bit at 0, the output is high during duty/128 of each carrier period, where duty is the 6-bit code. A duty of 0 keeps the output low.
- R4: With the polarity bit at 1, the output is low during duty/128 of each carrier period and high for the rest.
- R5: While the enable is 0 or power-down is 1, the output sits at the idle level: 0 for polarity 0 and 1 for polarity 1.
- R6: With the carrier select at 1 and the gate select at 0, the output is the plain carrier PWM. With both selects at 1, the carrier PWM appears only while the gate square wave is high, which is the second half of each gate period. During the first half the output holds the idle level.
- R7: With the carrier select at 0, the output holds the idle level whatever the gate select is.
- R8: A carrier code of 0 holds the output idle. A gate code of 0 also holds it idle whenever gating is selected.
- R9: While reset is asserted, the output is 0 and both accumulators are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| f1_code_i | input | 8 | Carrier frequency code |
| f2_code_i | input | 8 | Gate frequency code |
| range_i | input | 2 | Range select: 00 standard, 01 halved, 10 doubled, 11 as 00 |
| enable_i | input | 1 | Buzzer enable |
| invert_i | input | 1 | Polarity: 0 duty on logic 1, 1 duty on logic 0 |
| duty_i | input | 6 | Duty code in 1/128 of the carrier period |
| f1_sel_i | input | 1 | Carrier select |
| f2_sel_i | input | 1 | Gate select |
| powerdown_i | input | 1 | Power-down, forces idle |
| buzz_o | output | 1 | Buzzer drive |

## Verification
The bench counts high samples and rising edges over windows that span exactly one full output period. The counts therefore do not depend on the starting phase.

Each corner case targets a specific fault:
- The halved and doubled ranges catch a prescaler that taps the wrong count.
- The reserved range code catches a design that treats it as a fourth rate or stalls on it.
- Duty 0, duty 63 and the inverted polarity catch comparisons that are off by one or inverted.
- Gating with aligned periods exposes a gate running at the wrong phase or the wrong duty.
- The zero-code cases catch a design that leaves the output high at phase zero.
- The disabled and power-down cases with polarity 1 catch a block that idles low instead of at the polarity level.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

    typedef enum logic [1:0] {
        RANGE_STD  = 2'b00,
        RANGE_HALF = 2'b01,
        RANGE_DBL  = 2'b10,
        RANGE_RSVD = 2'b11
    } range_e;

    localparam int unsigned PRE_W = 2;

endpackage

// File: rtl/buzz_tick_gen.sv
module buzz_tick_gen
    import buzz_pkg::*;
#(
    parameter int unsigned BASE_DIV = 4
) (
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   run_i,
    input  range_e range_i,
    output logic   tick_o
);
    localparam int unsigned CNT_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BASE_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] div;
        logic [PRE_W-1:0] pre;
        logic             tick;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     base_hit;
    logic     range_hit;

    always_comb begin
        st_d     = st_q;
        base_hit = (st_q.div == CNT_LAST);
        unique case (range_i)
            RANGE_DBL:  range_hit = 1'b1;
            RANGE_HALF: range_hit = (st_q.pre == {PRE_W{1'b1}});
            default:    range_hit = st_q.pre[0];
        endcase
        if (!run_i) begin
            st_d = '0;
        end else begin
            st_d.div  = base_hit ? '0 : st_q.div + 1'b1;
            st_d.pre  = base_hit ? st_q.pre + 1'b1 : st_q.pre;
            st_d.tick = base_hit && range_hit;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign tick_o = st_q.tick;

endmodule

// File: rtl/buzz_phase_acc.sv
module buzz_phase_acc #(
    parameter int unsigned PHASE_W = 16,
    parameter int unsigned CODE_W  = 8,
    parameter int unsigned OUT_W   = 7
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [OUT_W-1:0]  top_o
);
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i)      st_d.phase = '0;
        else if (tick_i) st_d.phase = st_q.phase + PHASE_W'(code_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign top_o = st_q.phase[PHASE_W-1 -: OUT_W];

endmodule

// File: rtl/buzz_pwm_gen.sv
module buzz_pwm_gen
    import buzz_pkg::*;
#(
    parameter int unsigned BASE_DIV = 4,
    parameter int unsigned PHASE_W  = 16,
    parameter int unsigned FREQ_W   = 8,
    parameter int unsigned DUTY_W   = 6
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [FREQ_W-1:0] f1_code_i,
    input  logic [FREQ_W-1:0] f2_code_i,
    input  logic [1:0]        range_i,
    input  logic              enable_i,
    input  logic              invert_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              f1_sel_i,
    input  logic              f2_sel_i,
    input  logic              powerdown_i,
    output logic              buzz_o
);
    localparam int unsigned CMP_W = DUTY_W + 1;

    typedef struct packed {
        logic out;
    } out_st_t;

    out_st_t          st_d, st_q;
    logic             run;
    logic             tick;
    logic [CMP_W-1:0] f1_top;
    logic             gate;
    logic             pwm_hi;
    logic             gate_ok;
    logic             live;

    assign run = enable_i && !powerdown_i;

    buzz_tick_gen #(
        .BASE_DIV (BASE_DIV)
    ) i_tick (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .run_i   (run),
        .range_i (range_e'(range_i)),
        .tick_o  (tick)
    );

    buzz_phase_acc #(
        .PHASE_W (PHASE_W),
        .CODE_W  (FREQ_W),
        .OUT_W   (CMP_W)
    ) i_carrier (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (run),
        .tick_i (tick),
        .code_i (f1_code_i),
        .top_o  (f1_top)
    );

    buzz_phase_acc #(
        .PHASE_W (PHASE_W),
        .CODE_W  (FREQ_W),
        .OUT_W   (1)
    ) i_gate (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (run),
        .tick_i (tick),
        .code_i (f2_code_i),
        .top_o  (gate)
    );

    always_comb begin
        st_d    = st_q;
        pwm_hi  = (f1_top < {1'b0, duty_i});
        gate_ok = !f2_sel_i || ((f2_code_i != '0) && gate);
        live    = run && f1_sel_i && (f1_code_i != '0) && gate_ok;
        st_d.out = live ? (pwm_hi ^ invert_i) : invert_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign buzz_o = st_q.out;

endmodule

// File: rtl/buzz_pwm_chk.sv
module buzz_pwm_chk #(
    parameter int unsigned FREQ_W = 8,
    parameter int unsigned DUTY_W = 6
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [FREQ_W-1:0] f1_code_i,
    input logic [FREQ_W-1:0] f2_code_i,
    input logic              enable_i,
    input logic              invert_i,
    input logic [DUTY_W-1:0] duty_i,
    input logic              f1_sel_i,
    input logic              f2_sel_i,
    input logic              powerdown_i,
    input logic              buzz_o
);
    p_reset_low_r9: assert property (@(posedge clk_i)
        rst_i |=> (buzz_o == 1'b0));

    p_idle_off_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!enable_i || powerdown_i) |=> (buzz_o == $past(invert_i)));

    p_no_carrier_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !f1_sel_i |=> (buzz_o == $past(invert_i)));

    p_zero_code_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (f1_code_i == '0) |=> (buzz_o == $past(invert_i)));

    p_zero_gate_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (f2_sel_i && (f2_code_i == '0)) |=> (buzz_o == $past(invert_i)));

    p_zero_duty_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (duty_i == '0) |=> (buzz_o == $past(invert_i)));

endmodule

bind buzz_pwm_gen buzz_pwm_chk #(
    .FREQ_W (FREQ_W),
    .DUTY_W (DUTY_W)
) i_chk (.*);

// File: tb/test_buzz_pwm_gen.sv
module test_buzz_pwm_gen;

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic [7:0] f1_code_i = '0;
    logic [7:0] f2_code_i = '0;
    logic [1:0] range_i = '0;
    logic       enable_i = 1'b0;
    logic       invert_i = 1'b0;
    logic [5:0] duty_i = '0;
    logic       f1_sel_i = 1'b0;
    logic       f2_sel_i = 1'b0;
    logic       powerdown_i = 1'b0;
    logic       buzz_o;

    always #2 clk_i = ~clk_i;

    buzz_pwm_gen #(
        .BASE_DIV (1)
    ) i_buzz_pwm_gen (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .f1_code_i   (f1_code_i),
        .f2_code_i   (f2_code_i),
        .range_i     (range_i),
        .enable_i    (enable_i),
        .invert_i    (invert_i),
        .duty_i      (duty_i),
        .f1_sel_i    (f1_sel_i),
        .f2_sel_i    (f2_sel_i),
        .powerdown_i (powerdown_i),
        .buzz_o      (buzz_o)
    );

    typedef struct {
        string req;
        int    win;
        int    ones;
        int    rises;
    } item_t;

    item_t q[$];
    int    pushed = 0;
    int    popped = 0;
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    ended  = 1'b0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(input string req, input bit en, input bit pd, input bit inv,
                            input logic [1:0] rng, input logic [7:0] c1, input logic [7:0] c2,
                            input logic [5:0] d, input bit s1, input bit s2,
                            input int win, input int ones, input int rises);
        item_t it;
        enable_i = 1'b0;
        repeat (4) @(posedge clk_i);
        #1;
        powerdown_i = pd; invert_i = inv; range_i = rng;
        f1_code_i = c1; f2_code_i = c2; duty_i = d;
        f1_sel_i = s1; f2_sel_i = s2; enable_i = en;
        repeat (8) @(posedge clk_i);
        it.req = req; it.win = win; it.ones = ones; it.rises = rises;
        q.push_back(it);
        pushed++;
        wait (popped == pushed);
    endtask

    initial begin : monitor
        forever begin
            item_t it;
            int    ones;
            int    rises;
            logic  prev;
            wait (pushed > popped);
            it = q.pop_front();
            @(negedge clk_i);
            prev = buzz_o;
            ones = 0;
            rises = 0;
            for (int i = 0; i < it.win; i++) begin
                @(negedge clk_i);
                if (buzz_o) ones++;
                if (!prev && buzz_o) rises++;
                prev = buzz_o;
            end
            check(it.req, "high samples", ones, it.ones);
            check(it.req, "rising edges", rises, it.rises);
            popped++;
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : driver
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        check("R9", "output in reset", int'(buzz_o), 0);
        #1 rst_i = 1'b0;

        // R1: standard range, code 128 -> 1024 clocks, duty 32 -> 256 high
        run_case("R1", 1, 0, 0, 2'b00, 8'd128, 8'd0, 6'd32, 1, 0, 1024, 256, 1);
        // R1: code 64 -> 2048 clocks
        run_case("R1", 1, 0, 0, 2'b00, 8'd64, 8'd0, 6'd32, 1, 0, 2048, 512, 1);
        // R2: halved and doubled ranges, reserved code as standard
        run_case("R2", 1, 0, 0, 2'b01, 8'd128, 8'd0, 6'd32, 1, 0, 2048, 512, 1);
        run_case("R2", 1, 0, 0, 2'b10, 8'd128, 8'd0, 6'd32, 1, 0, 1024, 256, 2);
        run_case("R2", 1, 0, 0, 2'b11, 8'd128, 8'd0, 6'd32, 1, 0, 1024, 256, 1);
        // R3: duty extremes
        run_case("R3", 1, 0, 0, 2'b00, 8'd128, 8'd0, 6'd63, 1, 0, 1024, 504, 1);
        run_case("R3", 1, 0, 0, 2'b00, 8'd128, 8'd0, 6'd0, 1, 0, 1024, 0, 0);
        // R4: inverted polarity
        run_case("R4", 1, 0, 1, 2'b00, 8'd128, 8'd0, 6'd32, 1, 0, 1024, 768, 1);
        // R5: disabled and powered down idle at polarity level
        run_case("R5", 0, 0, 1, 2'b00, 8'd128, 8'd0, 6'd32, 1, 0, 1024, 1024, 0);
        run_case("R5", 1, 1, 1, 2'b00, 8'd128, 8'd0, 6'd32, 1, 0, 1024, 1024, 0);
        run_case("R5", 1, 1, 0, 2'b00, 8'd128, 8'd0, 6'd32, 1, 0, 1024, 0, 0);
        // R6: gated by f2 code 16 -> 8192 clocks, 4 carrier pulses
        run_case("R6", 1, 0, 0, 2'b00, 8'd128, 8'd16, 6'd32, 1, 1, 8192, 1024, 4);
        run_case("R6", 1, 0, 1, 2'b00, 8'd128, 8'd16, 6'd32, 1, 1, 8192, 7168, 4);
        // R7: carrier not selected
        run_case("R7", 1, 0, 0, 2'b00, 8'd128, 8'd16, 6'd32, 0, 1, 1024, 0, 0);
        // R8: zero carrier code, zero gate code
        run_case("R8", 1, 0, 0, 2'b00, 8'd0, 8'd0, 6'd32, 1, 0, 1024, 0, 0);
        run_case("R8", 1, 0, 1, 2'b00, 8'd0, 8'd0, 6'd32, 1, 0, 1024, 1024, 0);
        run_case("R8", 1, 0, 0, 2'b00, 8'd128, 8'd0, 6'd32, 1, 1, 1024, 0, 0);

        finish_run();
    end

endmodule